// File: doc/BRIEF.md
# Dual-Mode Ten-Bit Serializer Transmitter

This block is the transmit half of a gigabit-class serial link. A protocol controller hands it code groups that are already 8b/10b encoded, and the block sends each group out one bit at a time on a single serial output. Two clocks come in. The reference clock paces the parallel interface. The bit clock runs at ten times that rate, is edge-aligned with it, and drives the shift register. The clock multiplier that produces the bit clock lies outside the block.

The parallel side works in one of two formats. In full-word mode, all ten data inputs are captured together on each rising reference edge. In half-word mode, only the five low data inputs are used, and they are captured on both reference edges. The rising edge supplies the first half of the code group and the falling edge supplies the second. A per-word load strobe marks whether the word on the inputs is valid. The mode input is latched only while reset is asserted. Each captured word crosses into the bit-clock shift register through a holding register that is loaded once per word period. The block emits a bit-valid flag alongside the serial data.

Top module: `ser10_tx`

## Requirements
- R1: While reset is asserted, and after it is released until the first word loaded with the strobe high reaches the output, `ser_out` is at the idle level (low by default) and `bit_valid` is low.
- R2: With `mode_ddr` low during reset, `tx_data[9:0]` and `load_en` are captured on a rising `ref_clk` edge. Bit i of that word is on `ser_out` for the bit period that starts 10+i bit-clock edges after the capture edge, so bit 9 leaves 19 bit times after the load, inside the 19 to 20 window.
- R3: With `mode_ddr` high during reset, `tx_data[4:0]` and `load_en` on a rising edge give code bits 4..0, `tx_data[4:0]` on the next falling edge give code bits 9..5, and `tx_data[9:5]` is ignored.
- R4: In half-word mode, bit i of a word whose first half was captured on a rising edge is on `ser_out` for the bit period that starts 20+i edges after that edge, so bit 9 leaves after 29 bit times, inside the 29 to 30 window.
- R5: One code group goes out per reference period, least significant bit first. Valid words on consecutive periods run back to back with no gap, and `bit_valid` only changes at word boundaries, every ten bit times.
- R6: A word whose `load_en` was low at its rising capture edge produces ten bit times of the idle level with `bit_valid` low. Whenever `bit_valid` is low, `ser_out` is at the idle level.
- R7: `mode_ddr` is sampled only while reset is asserted. Changing it afterwards has no effect on capture or on timing until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, ten times the reference rate, edge-aligned with it |
| ref_clk | input | 1 | Reference clock for the parallel interface |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| mode_ddr | input | 1 | Interface select latched in reset: 0 selects full word, 1 selects half-word on both edges |
| load_en | input | 1 | Word-valid strobe, sampled on the rising reference edge |
| tx_data | input | 10 | Encoded code group; only bits 4..0 are used in half-word mode |
| ser_out | output | 1 | Serial data, bit 0 first |
| bit_valid | output | 1 | High while a valid code group is being shifted out |

## Verification
A fault in the capture registers or in the half-word join shows up as a wrong bit at a fixed position within the word on `ser_out`, ten or twenty bit times after the load. A phase counter that is misaligned, or a holding register loaded at the wrong phase, moves every word by one or more bit times. That breaks the exact latency checked on every bit period from the first word onward. A wrong `bit_valid` register, or a shifter that does not shift in the idle level, becomes visible within one word period as a valid flag at the wrong time or a non-idle bit between words.

// File: rtl/ser10_pkg.sv
package ser10_pkg;
    localparam int CODE_W       = 10;
    localparam int HALF_W       = CODE_W / 2;
    localparam int BITS_PER_REF = CODE_W;
    localparam int PH_W         = $clog2(BITS_PER_REF);
    localparam int HOLD_PH      = BITS_PER_REF / 2 - 1;
    localparam int LAST_PH      = BITS_PER_REF - 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [PH_W-1:0]   phase_t;

    typedef enum logic {
        IF_FULL     = 1'b0,
        IF_HALF_DDR = 1'b1
    } if_mode_e;

    typedef struct packed {
        logic  vld;
        code_t code;
    } word_t;

    localparam word_t WORD_NONE = '{vld: 1'b0, code: '0};

    function automatic code_t join_halves(half_t lo, half_t hi);
        return {hi, lo};
    endfunction

    function automatic phase_t phase_step(phase_t p);
        return (p == phase_t'(LAST_PH)) ? '0 : p + 1'b1;
    endfunction
endpackage

// File: rtl/ser10_word_capture.sv
module ser10_word_capture
    import ser10_pkg::*;
(
    input  logic  ref_clk,
    input  logic  rst,
    input  logic  mode_in,
    input  logic  load_en,
    input  code_t tx_data,
    output word_t word_q,
    output logic  tick_q,
    output logic  mode_lock
);
    if_mode_e mode_q;
    half_t    lo_q;
    logic     lo_vld_q;
    half_t    hi_q;

    // rising edge: mode latch (reset only), first half or full word, period tick
    always_ff @(posedge ref_clk) begin
        if (rst) begin
            mode_q   <= if_mode_e'(mode_in);
            lo_q     <= '0;
            lo_vld_q <= 1'b0;
            word_q   <= WORD_NONE;
            tick_q   <= 1'b0;
        end else begin
            tick_q   <= ~tick_q;
            lo_q     <= tx_data[HALF_W-1:0];
            lo_vld_q <= load_en;
            if (mode_q == IF_FULL) begin
                word_q <= '{vld: load_en, code: tx_data};
            end else begin
                word_q <= '{vld: lo_vld_q, code: join_halves(lo_q, hi_q)};
            end
        end
    end

    // falling edge: second half of a half-word pair
    always_ff @(negedge ref_clk) begin
        if (rst) begin
            hi_q <= '0;
        end else begin
            hi_q <= tx_data[HALF_W-1:0];
        end
    end

    assign mode_lock = (mode_q == IF_HALF_DDR);
endmodule

// File: rtl/ser10_phase_track.sv
module ser10_phase_track
    import ser10_pkg::*;
(
    input  logic   bit_clk,
    input  logic   rst,
    input  logic   tick_in,
    output phase_t phase_q
);
    logic tick_d;
    logic resync;

    assign resync = tick_in ^ tick_d;

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            tick_d  <= 1'b0;
            phase_q <= '0;
        end else begin
            tick_d  <= tick_in;
            phase_q <= resync ? phase_t'(1) : phase_step(phase_q);
        end
    end
endmodule

// File: rtl/ser10_shift_out.sv
module ser10_shift_out
    import ser10_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic   bit_clk,
    input  logic   rst,
    input  phase_t phase,
    input  word_t  word_in,
    output logic   ser_out,
    output logic   bit_valid
);
    localparam code_t IDLE_WORD = {CODE_W{IDLE_LEVEL}};

    word_t hold_q;
    code_t sh_q;
    logic  vld_q;

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            hold_q <= WORD_NONE;
            sh_q   <= IDLE_WORD;
            vld_q  <= 1'b0;
        end else begin
            if (phase == phase_t'(HOLD_PH)) begin
                hold_q <= word_in;
            end
            if (phase == phase_t'(LAST_PH)) begin
                vld_q <= hold_q.vld;
                sh_q  <= hold_q.vld ? hold_q.code : IDLE_WORD;
            end else begin
                sh_q  <= {IDLE_LEVEL, sh_q[CODE_W-1:1]};
            end
        end
    end

    assign ser_out   = sh_q[0];
    assign bit_valid = vld_q;
endmodule

// File: rtl/ser10_tx.sv
module ser10_tx
    import ser10_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic              bit_clk,
    input  logic              ref_clk,
    input  logic              rst,
    input  logic              mode_ddr,
    input  logic              load_en,
    input  logic [CODE_W-1:0] tx_data,
    output logic              ser_out,
    output logic              bit_valid
);
    word_t  word_w;
    logic   tick_w;
    logic   mode_lock;
    phase_t phase_w;

    ser10_word_capture u_cap (
        .ref_clk   (ref_clk),
        .rst       (rst),
        .mode_in   (mode_ddr),
        .load_en   (load_en),
        .tx_data   (tx_data),
        .word_q    (word_w),
        .tick_q    (tick_w),
        .mode_lock (mode_lock)
    );

    ser10_phase_track u_phase (
        .bit_clk (bit_clk),
        .rst     (rst),
        .tick_in (tick_w),
        .phase_q (phase_w)
    );

    ser10_shift_out #(.IDLE_LEVEL(IDLE_LEVEL)) u_shift (
        .bit_clk   (bit_clk),
        .rst       (rst),
        .phase     (phase_w),
        .word_in   (word_w),
        .ser_out   (ser_out),
        .bit_valid (bit_valid)
    );
endmodule

// File: rtl/ser10_tx_chk.sv
module ser10_tx_chk
    import ser10_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input logic bit_clk,
    input logic rst,
    input logic ser_out,
    input logic bit_valid,
    input logic mode_lock
);
    logic         seen_q;
    logic         pbv_q;
    logic [PH_W-1:0] run_q;

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            pbv_q  <= 1'b0;
            run_q  <= '0;
        end else if (bit_valid != pbv_q) begin
            seen_q <= 1'b1;
            pbv_q  <= bit_valid;
            run_q  <= PH_W'(1);
        end else begin
            run_q  <= (run_q == PH_W'(BITS_PER_REF - 1)) ? '0 : run_q + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge bit_clk) disable iff (rst)
        $fell(rst) |-> (!bit_valid && ser_out == IDLE_LEVEL)); // R1

    AST_IDLE_WHEN_INVALID: assert property (@(posedge bit_clk) disable iff (rst)
        !bit_valid |-> (ser_out == IDLE_LEVEL)); // R6

    AST_VALID_ON_BOUNDARY: assert property (@(posedge bit_clk) disable iff (rst)
        (seen_q && (bit_valid != pbv_q)) |-> (run_q == '0)); // R5

    AST_MODE_LOCKED: assert property (@(posedge bit_clk) disable iff (rst)
        !rst |=> $stable(mode_lock)); // R7
endmodule

bind ser10_tx ser10_tx_chk #(.IDLE_LEVEL(IDLE_LEVEL)) u_chk (
    .bit_clk   (bit_clk),
    .rst       (rst),
    .ser_out   (ser_out),
    .bit_valid (bit_valid),
    .mode_lock (mode_lock)
);

// File: tb/sim_ser10_tx.sv
`timescale 1ns/1ps
module sim_ser10_tx;
    localparam logic IDLE = 1'b0;

    logic       bit_clk;
    logic       ref_clk;
    logic       rst;
    logic       mode_ddr;
    logic       load_en;
    logic [9:0] tx_data;
    logic       ser_out;
    logic       bit_valid;

    int edge_cnt = 0;
    int ph       = 0;
    int ph_now   = 0;
    int n_chk    = 0;
    int n_fail   = 0;

    logic [9:0] code_arr [0:63];
    bit         en_arr   [0:63];

    ser10_tx #(.IDLE_LEVEL(IDLE)) u0 (
        .bit_clk   (bit_clk),
        .ref_clk   (ref_clk),
        .rst       (rst),
        .mode_ddr  (mode_ddr),
        .load_en   (load_en),
        .tx_data   (tx_data),
        .ser_out   (ser_out),
        .bit_valid (bit_valid)
    );

    // 100 MHz bit clock; reference clock rises with every tenth bit edge
    initial begin
        bit_clk = 1'b0;
        ref_clk = 1'b0;
        forever begin
            #5;
            edge_cnt = edge_cnt + 1;
            ph_now   = ph;
            if (ph == 0)      ref_clk = 1'b1;
            else if (ph == 5) ref_clk = 1'b0;
            bit_clk = 1'b1;
            ph = (ph + 1) % 10;
            #5 bit_clk = 1'b0;
        end
    end

    task automatic check(input string tag, input logic act_s, input logic exp_s,
                         input logic act_v, input logic exp_v);
        n_chk++;
        if (act_s !== exp_s || act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s edge %0d: ser_out=%b bit_valid=%b expected ser_out=%b bit_valid=%b",
                     tag, edge_cnt, act_s, act_v, exp_s, exp_v);
        end
    endtask

    function automatic bit exp_en(input int k, input int nw);
        return (k < nw) ? en_arr[k] : 1'b0;
    endfunction

    task automatic fill_words(input int nw);
        for (int k = 0; k < nw; k++) begin
            case (k)
                0: begin code_arr[k] = 10'h3FF; en_arr[k] = 1'b1; end
                1: begin code_arr[k] = 10'h000; en_arr[k] = 1'b1; end
                2: begin code_arr[k] = 10'h155; en_arr[k] = 1'b1; end
                3: begin code_arr[k] = 10'h2AA; en_arr[k] = 1'b1; end
                4: begin code_arr[k] = 10'h001; en_arr[k] = 1'b1; end
                5: begin code_arr[k] = 10'h3FF; en_arr[k] = 1'b0; end
                6: begin code_arr[k] = 10'h200; en_arr[k] = 1'b1; end
                default: begin
                    code_arr[k] = 10'($urandom);
                    en_arr[k]   = ($urandom % 5) != 0;
                end
            endcase
        end
    endtask

    task automatic run_block(input bit ddr, input int nw, input bit flip);
        int e0;
        int lat;
        fill_words(nw);
        lat = ddr ? 20 : 10;
        rst = 1'b1; load_en = 1'b0; tx_data = '0; mode_ddr = ddr;
        repeat (25) @(negedge bit_clk);
        while (ph_now != 2) @(negedge bit_clk);
        rst = 1'b0;
        e0 = -1;
        for (int c = 0; c < nw * 10 + 40; c++) begin
            @(negedge bit_clk);
            if (e0 < 0 || edge_cnt - e0 - lat < 0) begin
                check("R1", ser_out, IDLE, bit_valid, 1'b0);
            end else begin
                int d;
                int k;
                int i;
                bit en;
                string tag;
                d  = edge_cnt - e0 - lat;
                k  = d / 10;
                i  = d % 10;
                en = exp_en(k, nw);
                if (!en)                  tag = "R6";
                else if (flip)            tag = "R7";
                else if (i == 9)          tag = ddr ? "R4" : "R2";
                else if (i == 0 && k > 0) tag = "R5";
                else                      tag = ddr ? "R3" : "R2";
                check(tag, ser_out, en ? code_arr[k][i] : IDLE, bit_valid, en);
            end
            if (ph_now == 9) begin
                int kk;
                if (e0 < 0) e0 = edge_cnt + 1;
                kk = (edge_cnt + 1 - e0) / 10;
                load_en = exp_en(kk, nw);
                if (kk < nw) begin
                    if (ddr) tx_data = {5'($urandom), code_arr[kk][4:0]};
                    else     tx_data = code_arr[kk];
                end else begin
                    tx_data = 10'($urandom);
                end
            end else if (ph_now == 4 && ddr && e0 >= 0) begin
                int kh;
                kh = (edge_cnt - 4 - e0) / 10;
                load_en = $urandom % 2;
                if (kh < nw) tx_data = {5'($urandom), code_arr[kh][9:5]};
                else         tx_data = 10'($urandom);
            end
            if (flip && c == nw * 5) mode_ddr = ~mode_ddr;
        end
    endtask

    initial begin
        void'($urandom(32'd20511));
        rst = 1'b1; mode_ddr = 1'b0; load_en = 1'b0; tx_data = '0;
        @(negedge bit_clk);
        check("R1", ser_out, IDLE, bit_valid, 1'b0);
        run_block(1'b0, 40, 1'b0); // R2 full-word mode
        run_block(1'b1, 40, 1'b0); // R3 R4 half-word mode
        run_block(1'b0, 30, 1'b1); // R7 mode change ignored
        run_block(1'b1, 30, 1'b1); // R7 mode change ignored
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule